// File: doc/BRIEF.md
# Serial Register Port with Selectable Output Edge

This block is a slave serial port that gives an external host read and write access to a small bank of 8-bit registers. Each transfer uses four signals: a shift clock, a serial data input, an active-low select and a serial data output. The input is always sampled on the rising shift-clock edge. A static edge-select input decides whether read data on the output changes on the rising or the falling edge. The host can therefore pick the edge that gives its own sampling the most margin.

The shift clock, data input and select are all oversampled by the system clock, which must run at least four times faster than the shift clock. They pass through synchronizers, and edges are found by comparing successive synchronized samples. A transfer has a fixed length of 16 bits. A write is committed only when the select is released after a complete frame. A read drives the addressed register onto the output during the data phase.

Top module: `serial_regport`

## Requirements
- R1: A frame is 16 bits shifted MSB first on the data input, sampled on rising shift-clock edges while select is low. Bit 15 is the direction flag (1 = read, 0 = write), bits 14..8 are the 7-bit register address, and bits 7..0 are the data.
- R2: A write frame updates its register only when select returns high after at least 16 bits. A frame with fewer bits leaves every register unchanged.
- R3: Rising shift-clock edges after the 16th within one select window are ignored. The write commits the data carried by the first 16 bits.
- R4: With edge-select low, the first read data bit (MSB) is driven at the first rising edge after the last address bit, which is the 9th rising edge. Each later rising edge presents the next bit.
- R5: With edge-select high, the first read data bit (MSB) is driven at the falling edge that follows the last address bit, which is the 8th falling edge. Each later falling edge presents the next bit.
- R6: The output enable is high only while select is low and a read frame is in its data phase. When it is low, the data output is 0. It drops once select is high.
- R7: Addresses at or above REG_COUNT (default 16) are unpopulated: writes to them change no register, and reads from them return 0.
- R8: A read frame never modifies a register, whatever bits the host shifts in during its data phase.
- R9: After reset, every register holds 0 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial shift clock from the host |
| cs_n | input | 1 | Active-low transfer select |
| sdi | input | 1 | Serial data input |
| upd_on_fall | input | 1 | Output edge select: 1 = falling, 0 = rising |
| sdo | output | 1 | Serial data output |
| sdo_en | output | 1 | Output enable for the serial data output |

## Verification
In rising-edge output mode, a single detected shift-clock rise both captures an input bit and advances the output shifter. At the 9th rise it also loads the read data, using the header captured one edge earlier. The bench provokes this with read frames in both edge modes and checks every data bit at the end of its low phase against the value written earlier. It also shifts arbitrary data-phase bits into read frames and confirms, with a second read, that they never reach the register. Short, long and out-of-range write frames are each judged by a later read of the targeted address.

// File: rtl/serial_regport.sv
`timescale 1ns/1ps
module serial_regport #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int REG_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n,
  input  logic sdi,
  input  logic upd_on_fall,
  output logic sdo,
  output logic sdo_en
);
  localparam int HDR   = 1 + ADDR_W;
  localparam int FRAME = HDR + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic [SYNC_STAGES-1:0] sck_q, sdi_q, csn_q;
  logic sck_d, csn_d;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] shreg, oreg;
  logic hdr_rd, loaded;
  logic [ADDR_W-1:0] hdr_addr;
  logic [REG_COUNT-1:0][DATA_W-1:0] regs;

  wire sck_s    = sck_q[SYNC_STAGES-1];
  wire sdi_s    = sdi_q[SYNC_STAGES-1];
  wire csn_s    = csn_q[SYNC_STAGES-1];
  wire rise     = sck_s & ~sck_d;
  wire fall     = ~sck_s & sck_d;
  wire act      = upd_on_fall ? fall : rise;
  wire csn_rise = csn_s & ~csn_d;
  wire in_range = ({1'b0, hdr_addr} < (ADDR_W+1)'(REG_COUNT));
  wire [IDX_W-1:0] idx = hdr_addr[IDX_W-1:0];
  wire [DATA_W-1:0] rdata = in_range ? regs[idx] : '0;

  assign sdo_en = ~csn_s & loaded;
  assign sdo    = sdo_en ? oreg[DATA_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      sdi_q    <= '0;
      csn_q    <= '1;
      sck_d    <= 1'b0;
      csn_d    <= 1'b1;
      cnt      <= '0;
      shreg    <= '0;
      oreg     <= '0;
      hdr_rd   <= 1'b0;
      hdr_addr <= '0;
      loaded   <= 1'b0;
      regs     <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-2:0], sclk_in};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], sdi};
      csn_q <= {csn_q[SYNC_STAGES-2:0], cs_n};
      sck_d <= sck_s;
      csn_d <= csn_s;
      if (csn_s) begin
        cnt    <= '0;
        hdr_rd <= 1'b0;
        loaded <= 1'b0;
        oreg   <= '0;
      end else begin
        if (rise && cnt < CNT_W'(FRAME)) begin
          shreg <= {shreg[DATA_W-2:0], sdi_s};
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(HDR - 1))
            {hdr_rd, hdr_addr} <= {shreg[ADDR_W-1:0], sdi_s};
        end
        if (act && hdr_rd && cnt >= CNT_W'(HDR)) begin
          if (!loaded) begin
            oreg   <= rdata;
            loaded <= 1'b1;
          end else begin
            oreg <= {oreg[DATA_W-2:0], 1'b0};
          end
        end
      end
      if (csn_rise && cnt == CNT_W'(FRAME) && !hdr_rd && in_range)
        regs[idx] <= shreg;
    end
  end

  a_r2_commit_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !csn_rise |=> $stable(regs));
  a_r8_read_frame_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_rise && hdr_rd) |=> $stable(regs));
  a_r7_unpopulated_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_rise && !in_range) |=> $stable(regs));
  a_r3_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME));
  a_r6_enable_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> hdr_rd);
  a_r4_output_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> ($stable(sdo) || !sdo_en));
endmodule

// File: tb/serial_regport_tb.sv
`timescale 1ns/1ps
module serial_regport_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b0, cs_n = 1'b1, sdi = 1'b0, upd_on_fall = 1'b0;
  logic sdo, sdo_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit en_seen_wr;

  always #2 clk = ~clk;

  serial_regport u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n), .sdi(sdi),
    .upd_on_fall(upd_on_fall), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit rw, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, input string req, output logic [7:0] rd);
    logic [15:0] bits;
    bits = {rw, a, d};
    rd = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int p = 0; p <= nbits; p++) begin
      int j;
      if (p < nbits) sdi = (p < 16) ? bits[15-p] : 1'b1;
      repeat (8) @(negedge clk);
      j = upd_on_fall ? p - 8 : p - 9;
      if (rw && j >= 0 && j < 8) begin
        rd[7-j] = sdo;
        check({req, " R6 enable in data phase"}, sdo_en, 1'b1);
      end
      if (!rw && sdo_en) en_seen_wr = 1'b1;
      if (p < nbits) begin
        sclk_in = 1'b1;
        repeat (8) @(negedge clk);
        sclk_in = 1'b0;
      end
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R9 enable low after reset", sdo_en, 1'b0);
    check("R9 sdo low after reset", sdo, 1'b0);
    xfer(1'b1, 7'h03, 8'h00, 16, "R9", r);
    check("R9 register zero after reset", r, 8'h00);
  endtask

  task automatic t_rise_mode();
    logic [7:0] r;
    upd_on_fall = 1'b0;
    xfer(1'b0, 7'h05, 8'hA5, 16, "R1", r);
    xfer(1'b1, 7'h05, 8'h00, 16, "R4", r);
    check("R1 R4 read back rising mode", r, 8'hA5);
  endtask

  task automatic t_fall_mode();
    logic [7:0] r;
    upd_on_fall = 1'b1;
    xfer(1'b0, 7'h0C, 8'h3C, 16, "R1", r);
    xfer(1'b1, 7'h0C, 8'h00, 16, "R5", r);
    check("R5 read back falling mode", r, 8'h3C);
    xfer(1'b1, 7'h05, 8'h00, 16, "R5", r);
    check("R5 earlier register falling mode", r, 8'hA5);
    upd_on_fall = 1'b0;
  endtask

  task automatic t_short();
    logic [7:0] r;
    xfer(1'b0, 7'h05, 8'hFF, 15, "R2", r);
    xfer(1'b1, 7'h05, 8'h00, 16, "R2", r);
    check("R2 short frame discarded", r, 8'hA5);
  endtask

  task automatic t_long();
    logic [7:0] r;
    xfer(1'b0, 7'h07, 8'h81, 20, "R3", r);
    xfer(1'b1, 7'h07, 8'h00, 16, "R3", r);
    check("R3 extra bits ignored", r, 8'h81);
  endtask

  task automatic t_range();
    logic [7:0] r;
    xfer(1'b0, 7'h40, 8'h77, 16, "R7", r);
    xfer(1'b1, 7'h40, 8'h00, 16, "R7", r);
    check("R7 unpopulated read zero", r, 8'h00);
    xfer(1'b1, 7'h00, 8'h00, 16, "R7", r);
    check("R7 no alias into register 0", r, 8'h00);
  endtask

  task automatic t_read_nowrite();
    logic [7:0] r;
    upd_on_fall = 1'b0;
    xfer(1'b1, 7'h05, 8'h5A, 16, "R8", r);
    check("R8 read with data bits", r, 8'hA5);
    upd_on_fall = 1'b1;
    xfer(1'b1, 7'h05, 8'hFF, 16, "R8", r);
    check("R8 register unchanged by reads", r, 8'hA5);
    upd_on_fall = 1'b0;
  endtask

  task automatic t_enable();
    logic [7:0] r;
    en_seen_wr = 1'b0;
    xfer(1'b0, 7'h02, 8'hFF, 16, "R6", r);
    check("R6 enable stays low in write frame", en_seen_wr, 1'b0);
    check("R6 enable low when deselected", sdo_en, 1'b0);
    check("R6 sdo low when deselected", sdo, 1'b0);
    xfer(1'b1, 7'h02, 8'h00, 16, "R6", r);
    check("R6 all-ones register read", r, 8'hFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_rise_mode();
    t_fall_mode();
    t_short();
    t_long();
    t_range();
    t_read_nowrite();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule